// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces periodic CAS-before-RAS refresh for a DRAM controller. A free-running prescaler supplies seven tap strobes. A 3-bit select code picks one of them as the count enable for an 8-bit up-counter. When the counter holds the compare value and an enable strobe arrives, the block clears the counter, sets a sticky match flag and, if periodic refresh is on, raises a refresh request to the memory sequencer. The request is held until the sequencer acknowledges it.

Software reaches the block through a one-cycle write strobe with a 2-bit register select and an 8-bit data bus:

| Select | Register |
|--------|----------|
| 0 | Control |
| 1 | Counter load |
| 2 | Compare value |
| 3 | Flag clear |

The control byte holds four fields:
- bits [2:0]: the clock-select code.
- bit 3: refresh enable.
- bit 4: refresh mode.
- bit 5: a write-enable hold hint, which is passed straight to the sequencer.

The current count, the match flag, the overflow status and the request are visible as outputs.

Top module: `refresh_timer`

## Requirements
- R1: After reset the count output, match flag, overflow status, request and hold hint are 0, the select code is 0, and the compare value is 0xFF. With select code 1 the first refresh period is therefore 512 clocks.
- R2: The prescaler is a counter that is cleared by reset and increments on every clock. Select code c (1..7) enables the counter on clocks where the low k prescaler bits are all ones, with k = 1, 3, 5, 7, 9, 11 and 12 for codes 1 to 7. This gives divide ratios 2, 8, 32, 128, 512, 2048 and 4096.
- R3: With select code 0 the counter holds its value.
- R4: A compare match occurs on an enabled count step while the count equals the compare value. On a match the count goes to 0x00 instead of incrementing. Successive requests are therefore (compare+1) × divide clocks apart.
- R5: A write to register 2 loads the compare value. In the same cycle it clears the count to 0x00, and this takes precedence over counting.
- R6: A write to register 1 loads the count. This takes precedence over a compare-match clear in the same cycle.
- R7: A compare match sets the flag. The flag stays set until a write to register 3 with data bit 0 equal to 1. That clear is ignored while refresh enable (control bit 3) is 1. A match still sets the flag when the counter is written in the same cycle.
- R8: A match raises the request only when control bit 3 is 1 and control bit 4 is 0. The request stays high until a cycle in which the acknowledge is high.
- R9: A match that raises a request while one is still pending and not being acknowledged sets a sticky overflow status. That match is not queued. Overflow is cleared by the same accepted clear write that clears the flag.
- R10: The hold-hint output equals control bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Write data |
| rfsh_ack_i | input | 1 | Sequencer acknowledge |
| rfsh_req_o | output | 1 | Refresh request |
| cnt_o | output | 8 | Current count |
| flag_o | output | 1 | Sticky compare-match flag |
| ovf_o | output | 1 | Sticky missed-request status |
| hold_we_o | output | 1 | Hold write-enable hint for the sequencer |

## Verification
The properties assume that the write strobe and the acknowledge change only between clock edges and are held for whole cycles. They also assume that only one register is written per cycle. The bench drives every write and acknowledge from the falling edge as one-cycle pulses.

The precedence case, a counter load in the exact cycle of a match, is aimed using the prescaler phase alone. The bench derives that phase from the number of clocks since reset release, as R2 defines it.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMP  = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             hold_we;
    logic             mode;
    logic             en;
    logic [SEL_W-1:0] cks;
  } ctrl_t;

  // low prescaler bits that must be all ones for select code c
  function automatic int unsigned tap_width(input int unsigned c);
    return (c < 7) ? (2 * c - 1) : 12;
  endfunction
endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler
  import rfsh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NSEL = 1 << SEL_W;
  localparam int unsigned PW   = tap_width(NSEL - 1);

  logic [PW-1:0]   presc_q;
  logic [NSEL-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) presc_q <= '0;
    else         presc_q <= presc_q + 1'b1;
  end

  assign tap[0] = 1'b0;  // code 0 = stopped
  for (genvar c = 1; c < NSEL; c++) begin : g_tap
    localparam int unsigned K = tap_width(c);
    assign tap[c] = &presc_q[K-1:0];
  end

  assign tick_o = tap[sel_i];
endmodule

// File: rtl/rfsh_counter.sv
module rfsh_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_cnt_i,
  input  logic             ld_cmp_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q;

  assign match_o = tick_i && (cnt_q == cmp_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '1;
    end else begin
      if (ld_cmp_i) cmp_q <= wdata_i;
      if (ld_cnt_i)                cnt_q <= wdata_i;
      else if (ld_cmp_i || match_o) cnt_q <= '0;
      else if (tick_i)             cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_req.sv
module rfsh_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic active_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic req_o,
  output logic ovf_o,
  output logic flag_o
);
  logic req_q, ovf_q, flag_q;
  logic new_req;

  assign new_req = match_i && active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      ovf_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q <= (req_q && !ack_i) || new_req;
      if (new_req && req_q && !ack_i) ovf_q <= 1'b1;
      else if (clr_i)                 ovf_q <= 1'b0;
      if (match_i)    flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign ovf_o  = ovf_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rfsh_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              rfsh_ack_i,
  output logic              rfsh_req_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o,
  output logic              ovf_o,
  output logic              hold_we_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] cks_w;
  logic             en_w, mode_w;
  logic             wr_ctrl, wr_cnt, wr_cmp, clr_ok;
  logic             tick, match;
  logic             unused_hi;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL));
  assign wr_cnt  = wr_en_i && (wr_addr_i == ADDR_W'(REG_CNT));
  assign wr_cmp  = wr_en_i && (wr_addr_i == ADDR_W'(REG_CMP));
  // clear refused while refresh is enabled
  assign clr_ok  = wr_en_i && (wr_addr_i == ADDR_W'(REG_CLR)) && wr_data_i[0] && !ctrl_q.en;

  assign unused_hi = ^wr_data_i[CNT_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  assign cks_w  = ctrl_q.cks;
  assign en_w   = ctrl_q.en;
  assign mode_w = ctrl_q.mode;

  rfsh_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cks_w),
    .tick_o (tick)
  );

  rfsh_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ld_cnt_i (wr_cnt),
    .ld_cmp_i (wr_cmp),
    .wdata_i  (wr_data_i),
    .cnt_o    (cnt_o),
    .match_o  (match)
  );

  rfsh_req u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match),
    .active_i (en_w && !mode_w),
    .ack_i    (rfsh_ack_i),
    .clr_i    (clr_ok),
    .req_o    (rfsh_req_o),
    .ovf_o    (ovf_o),
    .flag_o   (flag_o)
  );

  assign hold_we_o = ctrl_q.hold_we;
endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       rfsh_ack_i,
  input logic       rfsh_req_o,
  input logic [7:0] cnt_o,
  input logic       flag_o,
  input logic       ovf_o,
  input logic [2:0] cks_i,
  input logic       en_i,
  input logic       mode_i
);
  logic ld_any, clr_acc;
  assign ld_any  = wr_en_i && (wr_addr_i == 2'd1 || wr_addr_i == 2'd2);
  assign clr_acc = wr_en_i && wr_addr_i == 2'd3 && wr_data_i[0] && !en_i;

  p_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cks_i == 3'd0 && !ld_any) |=> $stable(cnt_o));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_any |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 8'd1 || cnt_o == 8'd0));

  p_cmp_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd2) |=> cnt_o == 8'd0);

  p_cnt_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1) |=> cnt_o == $past(wr_data_i));

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_acc) |=> flag_o);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_req_o && !rfsh_ack_i) |=> rfsh_req_o);

  p_req_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rfsh_req_o) |-> $past(en_i && !mode_i));

  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_acc) |=> ovf_o);
endmodule

bind refresh_timer refresh_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rfsh_ack_i (rfsh_ack_i),
  .rfsh_req_o (rfsh_req_o),
  .cnt_o      (cnt_o),
  .flag_o     (flag_o),
  .ovf_o      (ovf_o),
  .cks_i      (cks_w),
  .en_i       (en_w),
  .mode_i     (mode_w)
);

// File: tb/refresh_timer_test.sv
module refresh_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ack = 1'b0;
  logic       req, flag, ovf, hold_we;
  logic [7:0] cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int pcnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) pcnt <= pcnt + 1;
  end

  refresh_timer uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rfsh_ack_i (ack),
    .rfsh_req_o (req),
    .cnt_o      (cnt),
    .flag_o     (flag),
    .ovf_o      (ovf),
    .hold_we_o  (hold_we)
  );

  // {select code, compare value, expected period in clocks}
  localparam logic [26:0] VEC [7] = '{
    {3'd1, 8'd3, 16'd8},
    {3'd2, 8'd5, 16'd48},
    {3'd3, 8'd0, 16'd32},
    {3'd4, 8'd1, 16'd256},
    {3'd5, 8'd0, 16'd512},
    {3'd6, 8'd1, 16'd4096},
    {3'd7, 8'd2, 16'd12288}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input logic h, input logic m, input logic e, input logic [2:0] c);
    return {2'b00, h, m, e, c};
  endfunction

  task automatic wait_req();
    while (!req) @(negedge clk);
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic period(output int p);
    int t1;
    wait_req();
    t1 = cyc;
    ack_pulse();
    wait_req();
    p = cyc - t1;
    ack_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt", cnt, 0);
    chk("R1 flag", flag, 0);
    chk("R1 req", req, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 hold", hold_we, 0);

    // R1 default compare 0xFF, code 1 -> 256*2
    wr(2'd0, ctl(0, 0, 1, 3'd1));
    period(p);
    chk("R1 default period", p, 512);

    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'd0);
      wr(2'd2, VEC[i][23:16]);
      wr(2'd0, ctl(0, 0, 1, VEC[i][26:24]));
      period(p);
      chk($sformatf("R2 R4 period code %0d", VEC[i][26:24]), p, int'(VEC[i][15:0]));
    end

    // R3 stopped counter
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd5);
    repeat (40) @(negedge clk);
    chk("R3 hold", cnt, 5);

    // R5 compare write clears count
    wr(2'd2, 8'd200);
    wr(2'd0, ctl(0, 0, 0, 3'd1));
    repeat (20) @(negedge clk);
    chk("R5 counting", int'(cnt != 8'd0), 1);
    wr(2'd2, 8'd200);
    chk("R5 clear", cnt, 0);

    // R6 load at a match cycle
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd1);
    chk("R7 clear accepted", flag, 0);
    wr(2'd2, 8'd4);
    wr(2'd1, 8'd4);
    while (pcnt[0]) @(negedge clk);
    wr(2'd0, ctl(0, 0, 0, 3'd1));
    chk("R6 pre", cnt, 4);
    wr(2'd1, 8'd4);
    chk("R6 load wins", cnt, 4);
    chk("R7 match with load", flag, 1);
    repeat (2) @(negedge clk);
    chk("R4 wrap", cnt, 0);

    // R7 clear refused while enabled
    wr(2'd0, ctl(0, 0, 1, 3'd0));
    wr(2'd3, 8'd1);
    chk("R7 clear ignored", flag, 1);
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd1);
    chk("R7 clear", flag, 0);

    // R8 / R9 pending request and overflow
    wr(2'd2, 8'd1);
    wr(2'd0, ctl(0, 0, 1, 3'd1));
    wait_req();
    chk("R9 no ovf first", ovf, 0);
    repeat (10) @(negedge clk);
    chk("R8 held", req, 1);
    chk("R9 ovf", ovf, 1);
    wr(2'd0, ctl(0, 0, 1, 3'd0));
    ack_pulse();
    chk("R8 ack", req, 0);
    wr(2'd3, 8'd1);
    chk("R9 ovf kept", ovf, 1);
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd1);
    chk("R9 ovf clear", ovf, 0);
    chk("R7 flag clear", flag, 0);

    // R8 mode bit blocks requests
    wr(2'd0, ctl(0, 1, 1, 3'd1));
    repeat (20) @(negedge clk);
    chk("R8 mode no req", req, 0);
    chk("R7 mode flag", flag, 1);

    // R10 hold hint
    wr(2'd0, ctl(1, 0, 0, 3'd0));
    chk("R10 hold on", hold_we, 1);
    wr(2'd0, 8'd0);
    chk("R10 hold off", hold_we, 0);

    summary();
    $finish;
  end
endmodule